// File: doc/BRIEF.md
# Paged Address Relocation and Abort Unit

This block maps a 16-bit virtual address onto a physical address of up to 22 bits. The upper three address bits pick one of eight pages, and each page has a base register and a descriptor register. Kernel, supervisor and user mode each own a separate group of these registers, and each group is split into an instruction space and a data space. Every access is checked against the descriptor's access code and page length and against the installed memory size. When a check fails, the block raises an abort in the same cycle, supplies a trap vector and records the cause in its status register.

The processor drives an access request with the virtual address, the direction, the width, the space and a current/previous mode selector. The block returns either a physical address with a valid strobe, or an abort with a vector. A small register port loads and reads the page registers, the status register and the mode-control register. Run mode 2 has no register group of its own and shares the user group.

Top module: `page_reloc_unit`

## Requirements
- R1: While status bit 0 is clear, a valid access that does not abort returns a physical address equal to the zero-extended virtual address.
- R2: While status bit 0 is set, the physical address is the page's base register times 64 plus virtual bits 12:0. The page is selected by virtual bits 15:13. The sum keeps 22 bits when mode-control bit 4 is set and is cut to 18 bits otherwise.
- R3: The run mode is taken from cur_mode, or from prev_mode when req_prev is set. Mode 0 selects the kernel registers, 1 the supervisor registers and 3 the user registers.
- R4: A data access uses the data-space page registers only when the mode's enable bit in mode-control is set: bit 2 for kernel, bit 1 for supervisor, bit 0 for user. Every other access uses the instruction-space registers.
- R5: Descriptor bits 2:0 hold the access code. A write passes only with code 6. A read aborts with codes 0, 1, 3, 4 and 7. Both faults use vector 0o250. The cause is non-resident (status bit 15) for a read with code 0 or 4, and read-only (bit 13) otherwise.
- R6: Descriptor bits 14:8 hold a block limit, and the block number is virtual bits 12:6. With descriptor bit 3 clear, a block above the limit aborts. With bit 3 set, a block below the limit aborts. The vector is 0o250 and the cause is status bit 14.
- R7: A relocated physical address at or above MEM_LIMIT aborts with vector 0o004 and cause bit 15.
- R8: A word access at an odd virtual address aborts with vector 0o004, whether relocation is on or off, and records no cause. A byte access at an odd address is not affected. Checks take precedence in this order: odd address, access code, memory range, length.
- R9: A fault records a cause only while status bits 15:13 are all zero. It writes the cause bit, the run mode into bits 6:5 and the page into bits 3:1. All other status bits keep their values. While a cause is held, the status register changes only through a register write.
- R10: A write that aborts for access code, range or length sets bit 7 of the descriptor it used. A register write to a descriptor clears bits 7:4.
- R11: abort and trap_vec are combinational in the request cycle, and phys_valid is low whenever abort is high.
- R12: Status writes force bits 11:10 to zero. Mode-control writes keep only bits 5, 4, 2, 1 and 0.
- R13: cfg_sel selects the register on the port: 0 page base, 1 descriptor, 2 status, 3 mode-control. Page registers are indexed by cfg_mode, cfg_dspace and cfg_page. A write takes effect at the next clock edge, and cfg_rdata shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_va | input | 16 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_dspace | input | 1 | 1 = data access, 0 = instruction access |
| req_prev | input | 1 | Use the previous-mode field |
| cur_mode | input | 2 | Current run mode |
| prev_mode | input | 2 | Previous run mode |
| phys_addr | output | PA_W | Physical address |
| phys_valid | output | 1 | Physical access may proceed |
| abort | output | 1 | Access aborted |
| trap_vec | output | 9 | Trap vector for the abort |
| status_reg | output | 16 | Relocation status register |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register kind select |
| cfg_mode | input | 2 | Mode group for page registers |
| cfg_dspace | input | 1 | Space for page registers |
| cfg_page | input | 3 | Page number for page registers |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Selected register contents |

## Verification
A wrong page-register index or mode decode appears at phys_addr in the same cycle as the request. The bench catches it by giving every mode and space its own distinct base. Errors in the fault-decision logic appear at abort and trap_vec in the same cycle. A cause-recording or freeze error appears at status_reg one clock later. A lost or misplaced descriptor write-fault mark stays invisible until the descriptor is read back, so the bench reads it right after each faulting write.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  localparam int VA_W     = 16;
  localparam int WORD_W   = 16;
  localparam int PAGES    = 8;
  localparam int PG_W     = $clog2(PAGES);
  localparam int OFF_W    = VA_W - PG_W;
  localparam int BLK_SH   = 6;
  localparam int BLK_W    = OFF_W - BLK_SH;
  localparam int SETS     = 3;
  localparam int SET_W    = $clog2(SETS);
  localparam int ENTRIES  = SETS * 2 * PAGES;
  localparam int ENT_W    = SET_W + 1 + PG_W;
  localparam int WIDE_BIT = 4;
  localparam logic [8:0] VEC_BUS = 9'o004;
  localparam logic [8:0] VEC_MMU = 9'o250;
  localparam logic [WORD_W-1:0] PDR_WMASK  = 16'hFF0F;
  localparam logic [WORD_W-1:0] PDR_MARK   = 16'h0080;
  localparam logic [WORD_W-1:0] STAT_WMASK = 16'hF3FF;
  localparam logic [WORD_W-1:0] MCTL_WMASK = 16'o000067;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0, MODE_SUPV = 2'd1, MODE_RSVD = 2'd2, MODE_USER = 2'd3
  } run_mode_e;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0, SEL_DESC = 2'd1, SEL_STAT = 2'd2, SEL_MCTL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic nonres;
    logic length;
    logic rdonly;
  } cause_t;

  function automatic logic [SET_W-1:0] set_of(input logic [1:0] m);
    case (run_mode_e'(m))
      MODE_KERN: set_of = SET_W'(0);
      MODE_SUPV: set_of = SET_W'(1);
      default:   set_of = SET_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/reloc_regfile.sv
module reloc_regfile
  import reloc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [SET_W-1:0]  cfg_set,
  input  logic              cfg_d,
  input  logic [PG_W-1:0]   cfg_page,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              mark_en,
  input  logic [SET_W-1:0]  lk_set,
  input  logic              lk_d,
  input  logic [PG_W-1:0]   lk_page,
  output logic [WORD_W-1:0] lk_base,
  output logic [WORD_W-1:0] lk_desc,
  output logic [WORD_W-1:0] rd_base,
  output logic [WORD_W-1:0] rd_desc
);
  logic [ENTRIES*WORD_W-1:0] base_flat;
  logic [ENTRIES*WORD_W-1:0] desc_flat;
  logic [ENT_W-1:0] lk_idx;
  logic [ENT_W-1:0] cfg_idx;

  assign lk_idx  = {lk_set, lk_d, lk_page};
  assign cfg_idx = {cfg_set, cfg_d, cfg_page};

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar d = 0; d < 2; d++) begin : g_space
      for (genvar p = 0; p < PAGES; p++) begin : g_page
        localparam int IDX = (s * 2 + d) * PAGES + p;
        logic [WORD_W-1:0] base_q, base_d, desc_q, desc_d;
        logic base_en, desc_en, cfg_hit, mark_hit;

        always_comb begin
          cfg_hit  = cfg_we && (cfg_idx == ENT_W'(IDX));
          mark_hit = mark_en && (lk_idx == ENT_W'(IDX));
          base_en  = cfg_hit && (reg_sel_e'(cfg_sel) == SEL_BASE);
          desc_en  = (cfg_hit && (reg_sel_e'(cfg_sel) == SEL_DESC)) || mark_hit;
          base_d   = cfg_wdata;
          if (cfg_hit && (reg_sel_e'(cfg_sel) == SEL_DESC))
            desc_d = cfg_wdata & PDR_WMASK;
          else
            desc_d = desc_q | PDR_MARK;
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            base_q <= '0;
            desc_q <= '0;
          end else begin
            if (base_en) base_q <= base_d;
            if (desc_en) desc_q <= desc_d;
          end
        end

        assign base_flat[IDX*WORD_W +: WORD_W] = base_q;
        assign desc_flat[IDX*WORD_W +: WORD_W] = desc_q;
      end
    end
  end

  assign lk_base = base_flat[lk_idx*WORD_W +: WORD_W];
  assign lk_desc = desc_flat[lk_idx*WORD_W +: WORD_W];
  assign rd_base = base_flat[cfg_idx*WORD_W +: WORD_W];
  assign rd_desc = desc_flat[cfg_idx*WORD_W +: WORD_W];
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
  import reloc_pkg::*;
#(
  parameter int PA_W     = 22,
  parameter int NARROW_W = 18
) (
  input  logic [VA_W-1:0]   va,
  input  logic              use_prev,
  input  logic [1:0]        cur_mode,
  input  logic [1:0]        prev_mode,
  input  logic              dspace,
  input  logic [WORD_W-1:0] mctl,
  input  logic              reloc_on,
  input  logic [WORD_W-1:0] base,
  output logic [1:0]        run_mode,
  output logic [SET_W-1:0]  set_idx,
  output logic              use_d,
  output logic [PG_W-1:0]   page,
  output logic [PA_W-1:0]   pa
);
  localparam logic [PA_W-1:0] NARROW_MASK = PA_W'((64'd1 << NARROW_W) - 64'd1);

  logic              d_enable;
  logic [PA_W-1:0]   sum;

  always_comb begin
    run_mode = use_prev ? prev_mode : cur_mode;
    set_idx  = set_of(run_mode);
    page     = va[VA_W-1 -: PG_W];
    case (run_mode_e'(run_mode))
      MODE_KERN: d_enable = mctl[2];
      MODE_SUPV: d_enable = mctl[1];
      MODE_USER: d_enable = mctl[0];
      default:   d_enable = 1'b0;
    endcase
    use_d = dspace && d_enable;
    sum   = (PA_W'(base) << BLK_SH) + PA_W'(va[OFF_W-1:0]);
    if (!reloc_on)
      pa = PA_W'(va);
    else if (mctl[WIDE_BIT])
      pa = sum;
    else
      pa = sum & NARROW_MASK;
  end
endmodule

// File: rtl/reloc_fault_eval.sv
module reloc_fault_eval
  import reloc_pkg::*;
#(
  parameter int PA_W      = 22,
  parameter int MEM_LIMIT = 196608
) (
  input  logic              req_valid,
  input  logic              reloc_on,
  input  logic              is_write,
  input  logic              is_byte,
  input  logic [VA_W-1:0]   va,
  input  logic [WORD_W-1:0] desc,
  input  logic [PA_W-1:0]   pa,
  output logic              fault,
  output logic [8:0]        vec,
  output cause_t            cause,
  output logic              mark
);
  logic [2:0]       acode;
  logic             odd, ac_bad, ac_absent, beyond, len_bad;
  logic [BLK_W-1:0] blk, lim;

  always_comb begin
    acode     = desc[2:0];
    odd       = !is_byte && va[0];
    ac_absent = (acode == 3'd0) || (acode == 3'd4);
    if (is_write)
      ac_bad = (acode != 3'd6);
    else
      ac_bad = ac_absent || (acode == 3'd1) || (acode == 3'd3) || (acode == 3'd7);
    beyond  = (32'(pa) >= 32'(MEM_LIMIT));
    blk     = va[OFF_W-1:BLK_SH];
    lim     = desc[8 +: BLK_W];
    len_bad = desc[3] ? (blk < lim) : (blk > lim);
  end

  always_comb begin
    fault = 1'b0;
    vec   = VEC_BUS;
    cause = '0;
    mark  = 1'b0;
    if (req_valid) begin
      if (odd) begin
        fault = 1'b1;
      end else if (reloc_on) begin
        if (ac_bad) begin
          fault        = 1'b1;
          vec          = VEC_MMU;
          cause.nonres = !is_write && ac_absent;
          cause.rdonly = is_write || !ac_absent;
          mark         = is_write;
        end else if (beyond) begin
          fault        = 1'b1;
          cause.nonres = 1'b1;
          mark         = is_write;
        end else if (len_bad) begin
          fault        = 1'b1;
          vec          = VEC_MMU;
          cause.length = 1'b1;
          mark         = is_write;
        end
      end
    end
  end
endmodule

// File: rtl/reloc_status.sv
module reloc_status
  import reloc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              fault,
  input  cause_t            cause,
  input  logic [1:0]        run_mode,
  input  logic [PG_W-1:0]   page,
  output logic [WORD_W-1:0] stat_q,
  output logic [WORD_W-1:0] mctl_q
);
  logic [WORD_W-1:0] stat_d, mctl_d;
  logic              stat_en, mctl_en, record;

  always_comb begin
    record  = fault && (cause != '0) && (stat_q[15:13] == 3'b000);
    stat_en = 1'b0;
    stat_d  = stat_q;
    if (cfg_we && (reg_sel_e'(cfg_sel) == SEL_STAT)) begin
      stat_en = 1'b1;
      stat_d  = cfg_wdata & STAT_WMASK;
    end else if (record) begin
      stat_en = 1'b1;
      stat_d  = {cause, stat_q[12:7], run_mode, stat_q[4], page, stat_q[0]};
    end
    mctl_en = cfg_we && (reg_sel_e'(cfg_sel) == SEL_MCTL);
    mctl_d  = cfg_wdata & MCTL_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mctl_q <= '0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (mctl_en) mctl_q <= mctl_d;
    end
  end
endmodule

// File: rtl/page_reloc_unit.sv
module page_reloc_unit
  import reloc_pkg::*;
#(
  parameter int PA_W      = 22,
  parameter int NARROW_W  = 18,
  parameter int MEM_LIMIT = 196608
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [15:0]      req_va,
  input  logic             req_write,
  input  logic             req_byte,
  input  logic             req_dspace,
  input  logic             req_prev,
  input  logic [1:0]       cur_mode,
  input  logic [1:0]       prev_mode,
  output logic [PA_W-1:0]  phys_addr,
  output logic             phys_valid,
  output logic             abort,
  output logic [8:0]       trap_vec,
  output logic [15:0]      status_reg,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_dspace,
  input  logic [2:0]       cfg_page,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata
);
  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic [WORD_W-1:0] stat_q, mctl_q, lk_base, lk_desc, rd_base, rd_desc;
  logic [1:0]        run_mode;
  logic [SET_W-1:0]  set_idx;
  logic              use_d, fault, mark;
  logic [PG_W-1:0]   page;
  cause_t            cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  reloc_xlate #(.PA_W(PA_W), .NARROW_W(NARROW_W)) u_xlate (
    .va(req_va), .use_prev(req_prev), .cur_mode(cur_mode), .prev_mode(prev_mode),
    .dspace(req_dspace), .mctl(mctl_q), .reloc_on(stat_q[0]), .base(lk_base),
    .run_mode(run_mode), .set_idx(set_idx), .use_d(use_d), .page(page), .pa(phys_addr)
  );

  reloc_fault_eval #(.PA_W(PA_W), .MEM_LIMIT(MEM_LIMIT)) u_fault (
    .req_valid(req_valid), .reloc_on(stat_q[0]), .is_write(req_write), .is_byte(req_byte),
    .va(req_va), .desc(lk_desc), .pa(phys_addr),
    .fault(fault), .vec(trap_vec), .cause(cause), .mark(mark)
  );

  reloc_regfile u_regs (
    .clk(clk), .rst_n(rst_core_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_set(set_of(cfg_mode)), .cfg_d(cfg_dspace), .cfg_page(cfg_page), .cfg_wdata(cfg_wdata),
    .mark_en(mark), .lk_set(set_idx), .lk_d(use_d), .lk_page(page),
    .lk_base(lk_base), .lk_desc(lk_desc), .rd_base(rd_base), .rd_desc(rd_desc)
  );

  reloc_status u_stat (
    .clk(clk), .rst_n(rst_core_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fault(fault), .cause(cause), .run_mode(run_mode), .page(page),
    .stat_q(stat_q), .mctl_q(mctl_q)
  );

  assign abort      = fault;
  assign phys_valid = req_valid && !fault;
  assign status_reg = stat_q;

  always_comb begin
    case (reg_sel_e'(cfg_sel))
      SEL_BASE: cfg_rdata = rd_base;
      SEL_DESC: cfg_rdata = rd_desc;
      SEL_STAT: cfg_rdata = stat_q;
      default:  cfg_rdata = mctl_q;
    endcase
  end
endmodule

// File: rtl/page_reloc_unit_sva.sv
module page_reloc_unit_sva #(
  parameter int PA_W      = 22,
  parameter int MEM_LIMIT = 196608
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [15:0]     req_va,
  input logic            req_byte,
  input logic [PA_W-1:0] phys_addr,
  input logic            phys_valid,
  input logic            abort,
  input logic [8:0]      trap_vec,
  input logic [15:0]     status_reg,
  input logic            cfg_we,
  input logic [1:0]      cfg_sel
);
  logic stat_wr;
  assign stat_wr = cfg_we && (cfg_sel == 2'd2);

  a_r1_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !status_reg[0] && !abort) |-> (phys_addr == PA_W'(req_va)));

  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (phys_valid && status_reg[0]) |-> (32'(phys_addr) < 32'(MEM_LIMIT)));

  a_r8_odd_word: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_byte && req_va[0]) |-> (abort && trap_vec == 9'o004));

  a_r11_no_valid_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !phys_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!abort && !phys_valid));

  a_r5_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (trap_vec == 9'o004 || trap_vec == 9'o250));

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_reg[15:13] != 3'b000) && !stat_wr) |=> $stable(status_reg));

  a_r9_records: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && status_reg[0] && (status_reg[15:13] == 3'b000) && !stat_wr
     && !(!req_byte && req_va[0])) |=> $onehot(status_reg[15:13]));

  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_reg[11:10] == 2'b00);
endmodule

bind page_reloc_unit page_reloc_unit_sva #(.PA_W(PA_W), .MEM_LIMIT(MEM_LIMIT)) u_sva (
  .clk(clk), .rst_n(rst_core_n), .req_valid(req_valid), .req_va(req_va),
  .req_byte(req_byte), .phys_addr(phys_addr), .phys_valid(phys_valid), .abort(abort),
  .trap_vec(trap_vec), .status_reg(status_reg), .cfg_we(cfg_we), .cfg_sel(cfg_sel)
);

// File: tb/page_reloc_unit_test.sv
module page_reloc_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_byte = 0, req_dspace = 0, req_prev = 0;
  logic [15:0] req_va = '0;
  logic [1:0] cur_mode = 0, prev_mode = 0;
  logic [PA_W-1:0] phys_addr;
  logic phys_valid, abort;
  logic [8:0] trap_vec;
  logic [15:0] status_reg, cfg_rdata;
  logic cfg_we = 0, cfg_dspace = 0;
  logic [1:0] cfg_sel = 0, cfg_mode = 0;
  logic [2:0] cfg_page = 0;
  logic [15:0] cfg_wdata = 0;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [PA_W-1:0] s_pa;
  logic s_pv, s_ab;
  logic [8:0] s_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_reloc_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
    .req_byte(req_byte), .req_dspace(req_dspace), .req_prev(req_prev), .cur_mode(cur_mode),
    .prev_mode(prev_mode), .phys_addr(phys_addr), .phys_valid(phys_valid), .abort(abort),
    .trap_vec(trap_vec), .status_reg(status_reg), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_mode(cfg_mode), .cfg_dspace(cfg_dspace), .cfg_page(cfg_page), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] m, input logic d, input logic [2:0] p, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_mode = m; cfg_dspace = d; cfg_page = p; cfg_wdata = v;
    @(posedge clk);
    #1 cfg_we = 0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [1:0] m, input logic d, input logic [2:0] p, output logic [15:0] v);
    @(negedge clk);
    cfg_sel = sel; cfg_mode = m; cfg_dspace = d; cfg_page = p;
    #1 v = cfg_rdata;
  endtask

  task automatic acc(input logic [15:0] va, input logic w, input logic b, input logic ds,
                     input logic [1:0] cm, input logic pv, input logic [1:0] pm);
    @(negedge clk);
    req_valid = 1; req_va = va; req_write = w; req_byte = b; req_dspace = ds;
    cur_mode = cm; req_prev = pv; prev_mode = pm;
    #1;
    s_pa = phys_addr; s_pv = phys_valid; s_ab = abort; s_vec = trap_vec;
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic ok_map(input string req, input logic [31:0] exp_pa);
    chk(req, "no abort", 32'(s_ab), 0);
    chk(req, "valid", 32'(s_pv), 1);
    chk(req, "phys addr", 32'(s_pa), exp_pa);
  endtask

  task automatic bad_acc(input string req, input logic [8:0] vec);
    chk(req, "abort", 32'(s_ab), 1);
    chk(req, "no valid on abort R11", 32'(s_pv), 0);
    chk(req, "vector", 32'(s_vec), 32'(vec));
  endtask

  task automatic clear_status();
    wr(2'd2, 0, 0, 0, 16'h0001);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    #1;
    chk("R13", "status after reset", 32'(status_reg), 0);
    chk("R11", "valid idle", 32'(phys_valid), 0);
    rd(2'd0, 0, 0, 1, v);
    chk("R13", "base after reset", 32'(v), 0);
  endtask

  task automatic t_identity();
    acc(16'o123456, 0, 0, 0, 0, 0, 0);
    ok_map("R1", 32'd42798);
    acc(16'o123457, 0, 0, 0, 0, 0, 0);
    bad_acc("R8 reloc off", 9'o004);
    chk("R8", "no cause when off", 32'(status_reg), 0);
  endtask

  task automatic t_setup();
    wr(2'd0, 0, 0, 1, 16'o1000); wr(2'd1, 0, 0, 1, 16'h7F06);
    wr(2'd0, 1, 0, 1, 16'o2000); wr(2'd1, 1, 0, 1, 16'h7F06);
    wr(2'd0, 3, 0, 1, 16'o3000); wr(2'd1, 3, 0, 1, 16'h7F06);
    wr(2'd0, 0, 1, 1, 16'o4000); wr(2'd1, 0, 1, 1, 16'h7F06);
    wr(2'd0, 3, 1, 1, 16'o4400); wr(2'd1, 3, 1, 1, 16'h7F06);
    wr(2'd0, 0, 0, 2, 16'o7777); wr(2'd1, 0, 0, 2, 16'h7F06);
    wr(2'd0, 0, 0, 3, 16'd3071); wr(2'd1, 0, 0, 3, 16'h7F06);
    clear_status();
  endtask

  task automatic t_map_width();
    acc(16'o021234, 0, 0, 0, 0, 0, 0);
    ok_map("R2 kernel page1", 32'd33436);
    acc(16'o040100, 0, 0, 0, 0, 0, 0);
    ok_map("R2 18-bit wrap", 32'd0);
    wr(2'd3, 0, 0, 0, 16'h0010);
    acc(16'o040100, 0, 0, 0, 0, 0, 0);
    bad_acc("R2 22-bit beyond limit R7", 9'o004);
    chk("R7", "status nonres page2", 32'(status_reg), 32'h8005);
    clear_status();
    wr(2'd3, 0, 0, 0, 16'h0000);
  endtask

  task automatic t_range();
    acc(16'h603E, 0, 0, 0, 0, 0, 0);
    ok_map("R7 just below limit", 32'd196606);
    acc(16'h6040, 0, 0, 0, 0, 0, 0);
    bad_acc("R7 at limit", 9'o004);
    chk("R7", "status at limit", 32'(status_reg), 32'h8007);
    clear_status();
  endtask

  task automatic t_modes();
    acc(16'o021234, 0, 0, 0, 1, 0, 0);
    ok_map("R3 supervisor", 32'd66204);
    acc(16'o021234, 0, 0, 0, 0, 1, 3);
    ok_map("R3 previous user", 32'd98972);
    acc(16'o021234, 0, 0, 0, 3, 1, 0);
    ok_map("R3 previous kernel", 32'd33436);
  endtask

  task automatic t_dspace();
    acc(16'o021234, 0, 0, 1, 0, 0, 0);
    ok_map("R4 data with enable off", 32'd33436);
    wr(2'd3, 0, 0, 0, 16'h0004);
    acc(16'o021234, 0, 0, 1, 0, 0, 0);
    ok_map("R4 kernel data", 32'd131740);
    acc(16'o021234, 0, 0, 0, 0, 0, 0);
    ok_map("R4 kernel instr", 32'd33436);
    acc(16'o021234, 0, 0, 1, 3, 0, 0);
    ok_map("R4 user data bit0 clear", 32'd98972);
    wr(2'd3, 0, 0, 0, 16'h0001);
    acc(16'o021234, 0, 0, 1, 3, 0, 0);
    ok_map("R4 user data", 32'd148124);
    acc(16'o021234, 0, 0, 1, 0, 0, 0);
    ok_map("R4 kernel data bit2 clear", 32'd33436);
    wr(2'd3, 0, 0, 0, 16'h0000);
  endtask

  task automatic t_access();
    logic [15:0] v;
    for (int code = 0; code < 8; code++) begin
      logic rd_bad;
      rd_bad = (code == 0 || code == 1 || code == 3 || code == 4 || code == 7);
      wr(2'd1, 0, 0, 4, 16'h7F00 | 16'(code));
      acc(16'h8000, 0, 0, 0, 0, 0, 0);
      if (rd_bad) begin
        bad_acc("R5 read", 9'o250);
        chk("R5", "read cause", 32'(status_reg),
            (code == 0 || code == 4) ? 32'h8009 : 32'h2009);
        clear_status();
      end else ok_map("R5 read allowed", 32'd0);
      acc(16'h8000, 1, 0, 0, 0, 0, 0);
      if (code != 6) begin
        bad_acc("R5 write", 9'o250);
        chk("R5", "write cause", 32'(status_reg), 32'h2009);
        rd(2'd1, 0, 0, 4, v);
        chk("R10", "mark on faulting write", 32'(v), 32'h7F80 | code);
        clear_status();
      end else begin
        ok_map("R5 write allowed", 32'd0);
        rd(2'd1, 0, 0, 4, v);
        chk("R10", "no mark on good write", 32'(v), 32'h7F06);
      end
    end
  endtask

  task automatic t_length();
    logic [15:0] v;
    wr(2'd1, 0, 0, 5, 16'h0206);
    acc(16'hA080, 0, 0, 0, 0, 0, 0);
    ok_map("R6 up at limit", 32'd128);
    acc(16'hA0C0, 0, 0, 0, 0, 0, 0);
    bad_acc("R6 up above limit", 9'o250);
    chk("R6", "length cause", 32'(status_reg), 32'h400B);
    clear_status();
    acc(16'hA0C0, 1, 0, 0, 0, 0, 0);
    rd(2'd1, 0, 0, 5, v);
    chk("R10", "mark on length write", 32'(v), 32'h0286);
    clear_status();
    wr(2'd1, 0, 0, 5, 16'h7D0E);
    acc(16'hBF40, 0, 0, 0, 0, 0, 0);
    ok_map("R6 down at limit", 32'd8000);
    acc(16'hBF00, 0, 0, 0, 0, 0, 0);
    bad_acc("R6 down below limit", 9'o250);
    clear_status();
  endtask

  task automatic t_odd();
    acc(16'o020001, 0, 0, 0, 0, 0, 0);
    bad_acc("R8 odd word", 9'o004);
    chk("R8", "no cause on odd", 32'(status_reg), 32'h0001);
    acc(16'o020001, 0, 1, 0, 0, 0, 0);
    ok_map("R8 odd byte", 32'd32769);
  endtask

  task automatic t_freeze();
    acc(16'hC000, 0, 0, 0, 3, 0, 0);
    bad_acc("R9 user nonres", 9'o250);
    chk("R9", "recorded mode and page", 32'(status_reg), 32'h806D);
    acc(16'hA000, 0, 0, 0, 0, 0, 0);
    bad_acc("R9 second fault", 9'o250);
    chk("R9", "frozen", 32'(status_reg), 32'h806D);
    clear_status();
    chk("R9", "cleared by write", 32'(status_reg), 32'h0001);
  endtask

  task automatic t_masks();
    logic [15:0] v;
    wr(2'd2, 0, 0, 0, 16'hFFFF);
    chk("R12", "status mask", 32'(status_reg), 32'hF3FF);
    clear_status();
    wr(2'd3, 0, 0, 0, 16'hFFFF);
    rd(2'd3, 0, 0, 0, v);
    chk("R12", "mode-control mask", 32'(v), 32'h0037);
    wr(2'd3, 0, 0, 0, 16'h0000);
    wr(2'd1, 1, 1, 7, 16'hFFFF);
    rd(2'd1, 1, 1, 7, v);
    chk("R10", "desc write clears 7:4", 32'(v), 32'hFF0F);
    rd(2'd0, 3, 1, 1, v);
    chk("R13", "user data base readback", 32'(v), 32'o4400);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_identity();
    t_setup();
    t_map_width();
    t_range();
    t_modes();
    t_dspace();
    t_access();
    t_length();
    t_odd();
    t_freeze();
    t_masks();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule